// File: doc/BRIEF.md
# Circuit-Switched Mesh Router Node

This block is one node of a two-dimensional mesh on chip. It has five ports: north, south, east, west and local. Each port has an incoming and an outgoing channel, and each channel carries a request, a destination coordinate pair, a data word and a grant that runs in the opposite direction. A source opens a path by raising its request with a destination. Every node on the way reserves one output link and passes the request on. The far end answers with a grant, and the grant ripples back along the same links. Data moves only after the grant has arrived, and the source tears the path down by lowering its request.

Inside the node, a decoder per input picks the output by comparing the destination with the node's own coordinates, resolving the X axis first. A round-robin arbiter per output chooses among the inputs that compete for it. A small circuit table holds the live input-to-output connections. There are at most `MAX_CIRCUITS` of them, two by default, and the data crossbar is registered.

Top module: `cs_mesh_router`

## Requirements
- R1: After reset, every outgoing request, every upstream grant and every outgoing data word is zero.
- R2: Port indices are north 0, south 1, east 2, west 3, local 4. A destination with x greater than the node's x goes east, and a smaller x goes west. When x is equal, a larger y goes north, a smaller y goes south, and an equal pair goes to local.
- R3: One cycle after an input's request is sampled and a circuit is made, the chosen output's request is high. That output's destination field, as {x,y}, carries the requesting input's destination.
- R4: An input's grant rises one cycle after the downstream grant of its reserved output is sampled high. It is never high unless that input holds a circuit.
- R5: While a circuit's input grant is high, the output's data equals the input's data of the previous cycle. Before the grant arrives, and on any output without a circuit, the data word is zero.
- R6: One cycle after a holding input's request is sampled low, its output request, its input grant and its reservation are cleared. The output data returns to zero one cycle after that.
- R7: At most `MAX_CIRCUITS` circuits exist at once. An extra request waits without reserving anything and is served after a release.
- R8: At most one new circuit is made per cycle. When several outputs have a winner, the output with the lowest index is served first.
- R9: Each output's arbiter is round robin. After input i wins, the search starts at input i+1. The arbiter's pointer moves only when its output is actually reserved.
- R10: An output held by one circuit is not given to another input until it is released, and an input holds at most one circuit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_req | input | 5 | Circuit request, one bit per incoming port |
| in_dst_x | input | 5*XW | Destination x, one field per incoming port |
| in_dst_y | input | 5*YW | Destination y, one field per incoming port |
| in_data | input | 5*DW | Data word, one field per incoming port |
| in_grant | output | 5 | Grant returned upstream, one bit per incoming port |
| out_req | output | 5 | Circuit request forwarded, one bit per outgoing port |
| out_dst_x | output | 5*XW | Forwarded destination x per outgoing port |
| out_dst_y | output | 5*YW | Forwarded destination y per outgoing port |
| out_data | output | 5*DW | Registered data word per outgoing port |
| out_grant_in | input | 5 | Grant arriving from downstream, one bit per outgoing port |

## Verification
- **Request to reservation:** a reservation is visible one edge after the request is sampled. When two outputs compete in the same cycle, the second reservation appears one edge later.
- **Grant:** a grant shows at the input one edge after the downstream grant.
- **Data:** a data word appears one edge after it is driven.
- **Release:** a release clears the reservation in one edge. A waiting request then reserves on the following edge, and its grant returns one edge after that.

Each stimulus task pushes its expected values into a queue tagged with the exact edge count at which they fall due. A monitor samples two nanoseconds after each rising edge and compares only the entries due at that edge.

// File: rtl/cs_router_pkg.sv
package cs_router_pkg;

   localparam int unsigned NUM_PORTS = 5;

   typedef enum logic [2:0] {
      PORT_N = 3'd0,
      PORT_S = 3'd1,
      PORT_E = 3'd2,
      PORT_W = 3'd3,
      PORT_L = 3'd4
   } port_e;

endpackage

// File: rtl/cs_route_decode.sv
module cs_route_decode
   import cs_router_pkg::*;
#(
   parameter int XW     = 3,
   parameter int YW     = 3,
   parameter int NODE_X = 0,
   parameter int NODE_Y = 0
) (
   input  logic [XW-1:0] dst_x,
   input  logic [YW-1:0] dst_y,
   output port_e         dir
);

   localparam logic [XW-1:0] OWN_X = XW'(NODE_X);
   localparam logic [YW-1:0] OWN_Y = YW'(NODE_Y);

   generate
      if (NODE_X < 0 || NODE_X >= (1 << XW)) begin : g_bad_x
         $error("cs_route_decode: NODE_X does not fit in XW bits");
      end
      if (NODE_Y < 0 || NODE_Y >= (1 << YW)) begin : g_bad_y
         $error("cs_route_decode: NODE_Y does not fit in YW bits");
      end
   endgenerate

   // The X axis is resolved before Y; an exact match goes to the local port.
   always_comb begin
      if (dst_x > OWN_X)      dir = PORT_E;
      else if (dst_x < OWN_X) dir = PORT_W;
      else if (dst_y > OWN_Y) dir = PORT_N;
      else if (dst_y < OWN_Y) dir = PORT_S;
      else                    dir = PORT_L;
   end

endmodule

// File: rtl/cs_rr_arbiter.sv
module cs_rr_arbiter #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         adv,
   output logic [N-1:0] gnt
);

   localparam int PW = (N > 1) ? $clog2(N) : 1;

   logic [PW-1:0] ptr;
   logic [PW-1:0] win;
   logic          found;

   generate
      if (N < 2) begin : g_bad_n
         $error("cs_rr_arbiter: N must be at least 2");
      end
   endgenerate

   // Search begins at the pointer and wraps around.
   always_comb begin
      gnt   = '0;
      win   = '0;
      found = 1'b0;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = int'(ptr) + k;
         if (idx >= N) idx = idx - N;
         if (!found && req[idx]) begin
            gnt[idx] = 1'b1;
            win      = PW'(idx);
            found    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (adv && found) begin
         ptr <= (int'(win) == N - 1) ? '0 : PW'(int'(win) + 1);
      end
   end

   assert_onehot_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   assert_grant_in_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);

   assert_ptr_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr));

endmodule

// File: rtl/cs_circuit_table.sv
module cs_circuit_table #(
   parameter int NP   = 5,
   parameter int MAXC = 2,
   parameter int XW   = 3,
   parameter int YW   = 3,
   parameter int DW   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NP-1:0]      in_req,
   input  logic [NP*XW-1:0]   in_dst_x,
   input  logic [NP*YW-1:0]   in_dst_y,
   input  logic [NP*DW-1:0]   in_data,
   input  logic [NP-1:0]      out_grant_in,
   input  logic               alloc_valid,
   input  logic [$clog2(NP)-1:0] alloc_in,
   input  logic [$clog2(NP)-1:0] alloc_out,
   output logic [NP-1:0]      busy_in,
   output logic [NP-1:0]      busy_out,
   output logic               full,
   output logic [NP-1:0]      in_grant,
   output logic [NP-1:0]      out_req,
   output logic [NP*XW-1:0]   out_dst_x,
   output logic [NP*YW-1:0]   out_dst_y,
   output logic [NP*DW-1:0]   out_data
);

   localparam int IW = $clog2(NP);
   localparam int SW = (MAXC > 1) ? $clog2(MAXC) : 1;

   logic [MAXC-1:0] vld;
   logic [MAXC-1:0] sgnt;
   logic [MAXC-1:0] rel;
   logic [IW-1:0]   sin  [MAXC];
   logic [IW-1:0]   sout [MAXC];
   logic [XW-1:0]   sdx  [MAXC];
   logic [YW-1:0]   sdy  [MAXC];
   logic [SW-1:0]   free_idx;
   logic [NP*DW-1:0] data_d;

   generate
      if (MAXC < 1 || MAXC > NP) begin : g_bad_maxc
         $error("cs_circuit_table: MAXC must lie between 1 and NP");
      end
   endgenerate

   assign full = &vld;

   // Lowest free slot receives the next circuit.
   always_comb begin
      free_idx = '0;
      for (int s = MAXC - 1; s >= 0; s--) begin
         if (!vld[s]) free_idx = SW'(s);
      end
   end

   always_comb begin
      for (int s = 0; s < MAXC; s++) begin
         rel[s] = vld[s] && !in_req[sin[s]];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= '0;
         sgnt <= '0;
         for (int s = 0; s < MAXC; s++) begin
            sin[s]  <= '0;
            sout[s] <= '0;
            sdx[s]  <= '0;
            sdy[s]  <= '0;
         end
      end else begin
         for (int s = 0; s < MAXC; s++) begin
            if (rel[s]) begin
               vld[s]  <= 1'b0;
               sgnt[s] <= 1'b0;
            end else if (vld[s]) begin
               sgnt[s] <= out_grant_in[sout[s]];
            end else if (alloc_valid && free_idx == SW'(s)) begin
               vld[s]  <= 1'b1;
               sgnt[s] <= 1'b0;
               sin[s]  <= alloc_in;
               sout[s] <= alloc_out;
               sdx[s]  <= in_dst_x[alloc_in*XW +: XW];
               sdy[s]  <= in_dst_y[alloc_in*YW +: YW];
            end
         end
      end
   end

   always_comb begin
      busy_in   = '0;
      busy_out  = '0;
      in_grant  = '0;
      out_req   = '0;
      out_dst_x = '0;
      out_dst_y = '0;
      data_d    = '0;
      for (int s = 0; s < MAXC; s++) begin
         if (vld[s]) begin
            busy_in[sin[s]]               = 1'b1;
            busy_out[sout[s]]             = 1'b1;
            out_req[sout[s]]              = 1'b1;
            out_dst_x[sout[s]*XW +: XW]   = sdx[s];
            out_dst_y[sout[s]*YW +: YW]   = sdy[s];
            if (sgnt[s]) begin
               in_grant[sin[s]]           = 1'b1;
               data_d[sout[s]*DW +: DW]   = in_data[sin[s]*DW +: DW];
            end
         end
      end
   end

   // Registered crossbar stage.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_data <= '0;
      else        out_data <= data_d;
   end

   assert_circuit_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vld) <= MAXC);

   assert_one_new_per_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vld & ~$past(vld)) <= 1);

   assert_no_alloc_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !alloc_valid);

   generate
      for (genvar s = 0; s < MAXC; s++) begin : g_slot_chk
         assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (vld[s] && !in_req[sin[s]]) |=> !vld[s]);
         for (genvar t = s + 1; t < MAXC; t++) begin : g_pair
            assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
               !(vld[s] && vld[t] && (sout[s] == sout[t] || sin[s] == sin[t])));
         end
      end
   endgenerate

endmodule

// File: rtl/cs_mesh_router.sv
module cs_mesh_router
   import cs_router_pkg::*;
#(
   parameter int XW           = 3,
   parameter int YW           = 3,
   parameter int DW           = 8,
   parameter int NODE_X       = 2,
   parameter int NODE_Y       = 2,
   parameter int MAX_CIRCUITS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_PORTS-1:0]     in_req,
   input  logic [NUM_PORTS*XW-1:0]  in_dst_x,
   input  logic [NUM_PORTS*YW-1:0]  in_dst_y,
   input  logic [NUM_PORTS*DW-1:0]  in_data,
   output logic [NUM_PORTS-1:0]     in_grant,
   output logic [NUM_PORTS-1:0]     out_req,
   output logic [NUM_PORTS*XW-1:0]  out_dst_x,
   output logic [NUM_PORTS*YW-1:0]  out_dst_y,
   output logic [NUM_PORTS*DW-1:0]  out_data,
   input  logic [NUM_PORTS-1:0]     out_grant_in
);

   localparam int NP = NUM_PORTS;
   localparam int IW = $clog2(NP);

   port_e         dir      [NP];
   logic [NP-1:0] cand     [NP];
   logic [NP-1:0] arb_gnt  [NP];
   logic [NP-1:0] adv;
   logic [NP-1:0] busy_in;
   logic [NP-1:0] busy_out;
   logic          full;
   logic          alloc_valid;
   logic [IW-1:0] alloc_in;
   logic [IW-1:0] alloc_out;

   generate
      if (DW < 1 || XW < 1 || YW < 1) begin : g_bad_width
         $error("cs_mesh_router: widths must be positive");
      end

      for (genvar i = 0; i < NP; i++) begin : g_dec
         cs_route_decode #(
            .XW(XW), .YW(YW), .NODE_X(NODE_X), .NODE_Y(NODE_Y)
         ) u_dec (
            .dst_x (in_dst_x[i*XW +: XW]),
            .dst_y (in_dst_y[i*YW +: YW]),
            .dir   (dir[i])
         );
      end
   endgenerate

   // Candidate matrix: idle inputs asking for a free output.
   always_comb begin
      for (int o = 0; o < NP; o++) begin
         for (int i = 0; i < NP; i++) begin
            cand[o][i] = in_req[i] && (dir[i] == port_e'(o)) &&
                         !busy_in[i] && !busy_out[o];
         end
      end
   end

   generate
      for (genvar o = 0; o < NP; o++) begin : g_arb
         cs_rr_arbiter #(.N(NP)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (cand[o]),
            .adv   (adv[o]),
            .gnt   (arb_gnt[o])
         );
      end
   endgenerate

   // One new circuit per cycle, lowest output index first.
   always_comb begin
      alloc_valid = 1'b0;
      alloc_in    = '0;
      alloc_out   = '0;
      for (int o = 0; o < NP; o++) begin
         if (!alloc_valid && !full && (|arb_gnt[o])) begin
            alloc_valid = 1'b1;
            alloc_out   = IW'(o);
            for (int i = 0; i < NP; i++) begin
               if (arb_gnt[o][i]) alloc_in = IW'(i);
            end
         end
      end
   end

   always_comb begin
      for (int o = 0; o < NP; o++) begin
         adv[o] = alloc_valid && (alloc_out == IW'(o));
      end
   end

   cs_circuit_table #(
      .NP(NP), .MAXC(MAX_CIRCUITS), .XW(XW), .YW(YW), .DW(DW)
   ) u_table (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_req       (in_req),
      .in_dst_x     (in_dst_x),
      .in_dst_y     (in_dst_y),
      .in_data      (in_data),
      .out_grant_in (out_grant_in),
      .alloc_valid  (alloc_valid),
      .alloc_in     (alloc_in),
      .alloc_out    (alloc_out),
      .busy_in      (busy_in),
      .busy_out     (busy_out),
      .full         (full),
      .in_grant     (in_grant),
      .out_req      (out_req),
      .out_dst_x    (out_dst_x),
      .out_dst_y    (out_dst_y),
      .out_data     (out_data)
   );

   generate
      for (genvar p = 0; p < NP; p++) begin : g_port_chk
         assert_no_early_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_req[p]) |-> (out_data[p*DW +: DW] == '0));
         assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
            in_grant[p] |-> $past(in_req[p]));
      end
   endgenerate

endmodule

// File: tb/cs_mesh_router_bench.sv
`timescale 1ns/1ps
module cs_mesh_router_bench;

   localparam int XW = 3;
   localparam int YW = 3;
   localparam int DW = 8;
   localparam int NP = 5;

   // sel codes: 0 out_data[port], 1 out_req, 2 in_grant, 3 {out_dst_x,out_dst_y}[port]
   typedef struct {
      int    due;
      int    sel;
      int    port;
      int    val;
      string tag;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NP-1:0]      in_req = '0;
   logic [NP*XW-1:0]   in_dst_x = '0;
   logic [NP*YW-1:0]   in_dst_y = '0;
   logic [NP*DW-1:0]   in_data = '0;
   logic [NP-1:0]      in_grant;
   logic [NP-1:0]      out_req;
   logic [NP*XW-1:0]   out_dst_x;
   logic [NP*YW-1:0]   out_dst_y;
   logic [NP*DW-1:0]   out_data;
   logic [NP-1:0]      out_grant_in = '0;

   exp_t q[$];
   int   cyc = 0;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 0;

   always #2.5 clk = ~clk;

   cs_mesh_router #(
      .XW(XW), .YW(YW), .DW(DW), .NODE_X(2), .NODE_Y(2), .MAX_CIRCUITS(2)
   ) u_cs_mesh_router (
      .clk(clk), .rst_n(rst_n),
      .in_req(in_req), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
      .in_data(in_data), .in_grant(in_grant),
      .out_req(out_req), .out_dst_x(out_dst_x), .out_dst_y(out_dst_y),
      .out_data(out_data), .out_grant_in(out_grant_in)
   );

   function automatic int observe(int sel, int port);
      case (sel)
         0: return int'(out_data[port*DW +: DW]);
         1: return int'(out_req);
         2: return int'(in_grant);
         default: return int'({out_dst_x[port*XW +: XW], out_dst_y[port*YW +: YW]});
      endcase
   endfunction

   task automatic expect_at(int dly, int sel, int port, int val, string tag);
      exp_t e;
      e.due = cyc + dly; e.sel = sel; e.port = port; e.val = val; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive_req(int i, bit on, int x, int y);
      in_req[i] = on;
      in_dst_x[i*XW +: XW] = XW'(x);
      in_dst_y[i*YW +: YW] = YW'(y);
   endtask

   // Monitor: samples 2 ns after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         #2;
         for (int k = q.size() - 1; k >= 0; k--) begin
            if (q[k].due == cyc) begin
               int got;
               got = observe(q[k].sel, q[k].port);
               n_cmp++;
               if (got !== q[k].val) begin
                  n_bad++;
                  $display("FAIL %s sel=%0d port=%0d actual=%0h expected=%0h",
                           q[k].tag, q[k].sel, q[k].port, got, q[k].val);
               end
               q.delete(k);
            end
         end
      end
   end

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R1 reset state
      expect_at(1, 1, 0, 0, "R1 out_req");
      expect_at(1, 2, 0, 0, "R1 in_grant");
      expect_at(1, 0, 2, 0, "R1 out_data");
      tick();

      // R8: west->south and local->east in the same cycle
      drive_req(3, 1, 2, 0);
      drive_req(4, 1, 4, 2);
      in_data[4*DW +: DW] = 8'h77;
      expect_at(1, 1, 0, 5'b00010, "R8 lowest output first");
      expect_at(2, 1, 0, 5'b00110, "R8 second circuit next cycle");
      expect_at(2, 3, 2, (4 << 3) | 2, "R3 forwarded destination east");
      expect_at(2, 0, 2, 0, "R5 no data before grant");
      tick(2);

      // R4 grant returns, R5 data gated until then
      out_grant_in[2] = 1'b1;
      expect_at(1, 2, 0, 5'b10000, "R4 grant to local input");
      expect_at(1, 0, 2, 0, "R5 data zero on grant edge");
      tick();
      in_data[4*DW +: DW] = 8'h3c;
      expect_at(1, 0, 2, 8'h3c, "R5 data one cycle later");
      expect_at(1, 0, 0, 0, "R5 idle output zero");
      tick();
      in_data[4*DW +: DW] = 8'ha5;
      expect_at(1, 0, 2, 8'ha5, "R5 second word");
      tick();

      // R7: third request waits (north input to west)
      drive_req(0, 1, 0, 3);
      expect_at(1, 1, 0, 5'b00110, "R7 cap holds");
      expect_at(2, 1, 0, 5'b00110, "R7 cap still holds");
      tick(2);

      // R6 release of local->east, waiting request served after
      in_req[4] = 1'b0;
      out_grant_in[2] = 1'b0;
      expect_at(1, 1, 0, 5'b00010, "R6 out_req drops");
      expect_at(1, 2, 0, 0, "R6 grant drops");
      expect_at(2, 0, 2, 0, "R6 data returns to zero");
      expect_at(2, 1, 0, 5'b01010, "R7 waiting request served west (R2)");
      expect_at(2, 3, 3, (0 << 3) | 3, "R3 forwarded destination west");
      tick(2);

      // R10: east input wants west, held by north
      in_req[3] = 1'b0;
      tick();
      drive_req(2, 1, 0, 0);
      out_grant_in[3] = 1'b1;
      expect_at(1, 1, 0, 5'b01000, "R10 held output not shared");
      expect_at(2, 1, 0, 5'b01000, "R10 still held");
      expect_at(1, 2, 0, 5'b00001, "R4 grant to north input");
      tick(2);
      in_req[0] = 1'b0;
      expect_at(1, 1, 0, 0, "R6 release before handover");
      expect_at(2, 1, 0, 5'b01000, "R10 handed to east input");
      expect_at(3, 2, 0, 5'b00100, "R4 grant to east input");
      tick(3);
      in_req = '0;
      out_grant_in = '0;
      tick(2);

      // R9 round robin on the local output
      out_grant_in[4] = 1'b1;
      drive_req(0, 1, 2, 2);
      drive_req(3, 1, 2, 2);
      expect_at(1, 1, 0, 5'b10000, "R2 equal coordinates go local");
      expect_at(1, 3, 4, (2 << 3) | 2, "R3 forwarded destination local");
      expect_at(2, 2, 0, 5'b00001, "R9 first winner north");
      tick(2);
      in_req[0] = 1'b0;
      expect_at(1, 2, 0, 0, "R6 grant cleared");
      expect_at(3, 2, 0, 5'b01000, "R9 west wins after north");
      tick();
      in_req[0] = 1'b1;
      tick(2);
      in_req[3] = 1'b0;
      expect_at(3, 2, 0, 5'b00001, "R9 north served again");
      tick(3);

      in_req = '0;
      out_grant_in = '0;
      tick(3);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule